// File: doc/BRIEF.md
# I2C Target for a Voice-Coil DAC Code

This block is a two-wire bus target that holds the setting of a 10-bit current DAC and its power-down flag. SCL and SDA are sampled on the system clock. Start and stop conditions are detected from the synchronized lines. A seven-bit address is matched with its two lowest bits ignored. Each transfer carries a 16-bit word as two bytes. A complete write moves the word into an input register and into the DAC register. A read returns the input register and then clears it.

SDA is driven open-drain through `sda_oe`. When `sda_oe` is high the pad pulls the line low. When it is low the line is released. The DAC register drives `dac_code` from word bits 13..4 and `pwr_down` from word bit 15. Word bits 14 and 3..0 are not used.

The protocol engine has eight states:
- IDLE: the bus is free.
- ADDR: eight address bits are shifted in.
- ADDR_ACK: the address is acknowledged.
- WR_BYTE / WR_ACK: a data byte is received and acknowledged.
- RD_BYTE / RD_ACK: a data byte is sent and the master's acknowledge is sampled.
- IGNORE: the target stays silent until the next start.

Transitions:
- A start moves any state to ADDR.
- A stop moves any state to IDLE.
- ADDR goes to ADDR_ACK on the eighth bit if the address matches, and to IGNORE otherwise.
- ADDR_ACK goes to WR_BYTE or RD_BYTE at the end of the ninth clock, depending on the R/W bit.
- WR_BYTE goes to WR_ACK after eight bits.
- WR_ACK goes back to WR_BYTE after the first byte, and to IGNORE after the second.
- RD_BYTE goes to RD_ACK after eight bits.
- RD_ACK goes to RD_BYTE when the master acknowledges the first byte. It goes to IGNORE after the second byte or on a not-acknowledge.

Top module: `vcm_i2c_dac_target`

## Requirements
- R1: After reset, `dac_code` is 0, `pwr_down` is 0 and SDA is released (`sda_oe` = 0).
- R2: The target answers only when the seven address bits are 00011xx (bits 1..0 don't-care). The eighth bit is R/W: 0 means write, 1 means read. On any other address it never pulls SDA and ignores the data bytes that follow, until the next start.
- R3: The target holds SDA low from the SCL low phase before the ninth clock through the ninth clock. It does this for the address and for both write data bytes. A third write byte is not acknowledged.
- R4: Write data arrives high byte first, MSB first, and forms a 16-bit word. When the second byte is complete, `dac_code` takes word bits 13..4 and `pwr_down` takes word bit 15. Bits 14 and 3..0 have no effect on the outputs.
- R5: A write that ends, by stop or repeated start, before its second byte is complete changes neither the input register nor `dac_code`/`pwr_down`.
- R6: A read returns the input register as two bytes, high byte first, MSB first. `dac_code` and `pwr_down` are not changed by a read.
- R7: When the ninth clock of the second read byte has passed, the input register becomes all zeros. A read ended by a not-acknowledge after the first byte leaves it unchanged.
- R8: A repeated start during a transfer returns the target to address reception. A new transfer that follows is then handled in full.
- R9: SDA is only ever pulled low, and the target never begins pulling it while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| dac_code | output | 10 | DAC code from the DAC register |
| pwr_down | output | 1 | Active-high power-down level |

## Verification
The assertions check on every cycle that the target does the following:
- It keeps SDA released in IDLE and IGNORE.
- It never starts pulling SDA during an SCL high phase.
- It changes the DAC outputs only in the cycle after a completed write.
- It empties the input register right after a finished read.

Only the bench's scenarios can show the bus-level behaviour:
- Which addresses are acknowledged and the bit order of the returned bytes.
- That an aborted write or a not-acknowledged read leaves the stored word alone.
- That a repeated start restarts address reception.
- That the unused word bits never reach the outputs.

// File: rtl/vcm_i2c_pkg.sv
package vcm_i2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int CODE_W   = 10;
    localparam int CODE_LSB = 4;
    localparam int PD_BIT   = 15;
    localparam int CNT_W    = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } link_state_t;

endpackage

// File: rtl/vcm_line_sync.sv
module vcm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Bus lines idle high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign line_s = chain[STAGES-1];
    assign rise   = line_s & ~prev;
    assign fall   = ~line_s & prev;
endmodule

// File: rtl/vcm_code_regs.sv
module vcm_code_regs
    import vcm_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              clear,
    output logic [WORD_W-1:0] in_word,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down
);
    logic [WORD_W-1:0] in_q;
    logic [CODE_W-1:0] code_q;
    logic              pd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q   <= '0;
            code_q <= '0;
            pd_q   <= 1'b0;
        end else if (load) begin
            in_q   <= load_word;
            code_q <= load_word[CODE_LSB +: CODE_W];
            pd_q   <= load_word[PD_BIT];
        end else if (clear) begin
            in_q   <= '0;
        end
    end

    assign in_word  = in_q;
    assign dac_code = code_q;
    assign pwr_down = pd_q;
endmodule

// File: rtl/vcm_link_fsm.sv
module vcm_link_fsm
    import vcm_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'b0001100,
    parameter int         IGNORE_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [WORD_W-1:0] in_word,
    output logic              sda_oe,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word,
    output logic              rd_done,
    output link_state_t       state
);
    localparam int MATCH_W = 7 - IGNORE_LSB;

    link_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] shreg_q;
    logic [BYTE_W-1:0] hold_q;
    logic [WORD_W-1:0] tx_q;
    logic              rw_q, phase_q, second_q, oe_q;

    logic              start, stop, last_bit, addr_hit;
    logic [BYTE_W-1:0] byte_nx;

    assign start    = scl_s & sda_fall;
    assign stop     = scl_s & sda_rise;
    assign byte_nx  = {shreg_q, sda_s};
    assign last_bit = (cnt_q == CNT_W'(BYTE_W - 1));
    assign addr_hit = (byte_nx[BYTE_W-1 -: MATCH_W] == DEV_ADDR[6 -: MATCH_W]);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ADDR;
        end else if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:
                    if (scl_rise && last_bit)
                        state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:
                    if (scl_fall && phase_q)
                        state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:
                    if (scl_rise && last_bit) state_d = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall && phase_q)
                        state_d = second_q ? ST_IGNORE : ST_WR_BYTE;
                ST_RD_BYTE:
                    if (scl_rise && last_bit) state_d = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_rise && phase_q)
                        state_d = (second_q || sda_s) ? ST_IGNORE : ST_RD_BYTE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            hold_q   <= '0;
            tx_q     <= '0;
            rw_q     <= 1'b0;
            phase_q  <= 1'b0;
            second_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (start) begin
            cnt_q    <= '0;
            phase_q  <= 1'b0;
            second_q <= 1'b0;
            oe_q     <= 1'b0;
        end else if (stop) begin
            oe_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_q <= byte_nx[BYTE_W-2:0];
                        cnt_q   <= cnt_q + 1'b1;
                        if (last_bit) begin
                            rw_q    <= byte_nx[0];
                            tx_q    <= in_word;
                            phase_q <= 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) begin
                            oe_q    <= 1'b1;
                            phase_q <= 1'b1;
                        end else begin
                            phase_q <= 1'b0;
                            cnt_q   <= '0;
                            if (rw_q) begin
                                oe_q <= ~tx_q[WORD_W-1];
                                tx_q <= tx_q << 1;
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg_q <= byte_nx[BYTE_W-2:0];
                        cnt_q   <= cnt_q + 1'b1;
                        if (last_bit) begin
                            phase_q <= 1'b0;
                            if (!second_q) hold_q <= byte_nx;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) begin
                            oe_q    <= 1'b1;
                            phase_q <= 1'b1;
                        end else begin
                            oe_q     <= 1'b0;
                            phase_q  <= 1'b0;
                            cnt_q    <= '0;
                            second_q <= 1'b1;
                        end
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        oe_q <= ~tx_q[WORD_W-1];
                        tx_q <= tx_q << 1;
                    end
                    if (scl_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_bit) phase_q <= 1'b0;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall && !phase_q) begin
                        oe_q    <= 1'b0;
                        phase_q <= 1'b1;
                    end
                    if (scl_rise && phase_q && !second_q && !sda_s) begin
                        second_q <= 1'b1;
                        cnt_q    <= '0;
                    end
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit      = (state_q == ST_WR_BYTE) && scl_rise && last_bit && second_q
                      && !start && !stop;
        commit_word = {hold_q, byte_nx};
        rd_done     = (state_q == ST_RD_ACK) && scl_rise && phase_q && second_q
                      && !start && !stop;
        sda_oe      = oe_q;
        state       = state_q;
    end
endmodule

// File: rtl/vcm_i2c_dac_target.sv
module vcm_i2c_dac_target
    import vcm_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0001100,
    parameter int         IGNORE_LSB  = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down
);
    logic              scl_s, scl_rise, scl_fall;
    logic              sda_s, sda_rise, sda_fall;
    logic              wr_commit, rd_done;
    logic [WORD_W-1:0] commit_word, in_word;
    link_state_t       link_state;

    vcm_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .line_s(scl_s), .rise(scl_rise), .fall(scl_fall)
    );

    vcm_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .line_s(sda_s), .rise(sda_rise), .fall(sda_fall)
    );

    vcm_link_fsm #(.DEV_ADDR(DEV_ADDR), .IGNORE_LSB(IGNORE_LSB)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .in_word(in_word), .sda_oe(sda_oe),
        .commit(wr_commit), .commit_word(commit_word),
        .rd_done(rd_done), .state(link_state)
    );

    vcm_code_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .load(wr_commit), .load_word(commit_word), .clear(rd_done),
        .in_word(in_word), .dac_code(dac_code), .pwr_down(pwr_down)
    );
endmodule

// File: rtl/vcm_i2c_chk.sv
module vcm_i2c_chk
    import vcm_i2c_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic [CODE_W-1:0] dac_code,
    input logic              pwr_down,
    input logic              wr_commit,
    input logic              rd_done,
    input logic [WORD_W-1:0] in_word,
    input link_state_t       link_state
);
    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_IDLE) |-> !sda_oe);

    // R2
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_IGNORE) |-> !sda_oe);

    // R9
    no_pull_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && sda_oe) |-> $past(sda_oe));

    // R4
    dac_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_code) || !$stable(pwr_down)) |-> $past(wr_commit));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_done) |-> (in_word == '0));
endmodule

bind vcm_i2c_dac_target vcm_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .dac_code(dac_code), .pwr_down(pwr_down), .wr_commit(wr_commit),
    .rd_done(rd_done), .in_word(in_word), .link_state(link_state)
);

// File: tb/test_vcm_i2c_dac_target.sv
module test_vcm_i2c_dac_target;
    localparam int QTR = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [9:0] dac_code;
    logic       pwr_down;
    logic       sda_line;
    int         checks = 0;
    int         errors = 0;
    int         r9_viol = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    vcm_i2c_dac_target i_vcm_i2c_dac_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .dac_code(dac_code), .pwr_down(pwr_down)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    // R9 watch: the pull-down must not change during a high phase
    task automatic put_bit(input logic b, output logic seen);
        logic o_a;
        sda_m = b; q();
        scl_m = 1'b1; q();
        o_a  = sda_oe;
        seen = sda_line;
        q();
        if (sda_oe !== o_a) r9_viol++;
        scl_m = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s);
            d = {d[6:0], s};
        end
        put_bit(!give_ack, s);
    endtask

    task automatic wr_word(input logic [7:0] ab, input logic [15:0] w,
                           output logic a0, output logic a1, output logic a2);
        bus_start();
        send_byte(ab, a0);
        send_byte(w[15:8], a1);
        send_byte(w[7:0], a2);
        bus_stop();
    endtask

    task automatic rd_word(input logic full, output logic a0, output logic [15:0] w);
        logic [7:0] hi, lo;
        bus_start();
        send_byte(8'h19, a0);
        get_byte(full, hi);
        lo = '0;
        if (full) get_byte(1'b0, lo);
        bus_stop();
        w = {hi, lo};
    endtask

    task automatic t_reset();
        chk("R1 code", int'(dac_code), 0);
        chk("R1 pd", int'(pwr_down), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
    endtask

    task automatic t_write_basic();
        logic a0, a1, a2;
        wr_word(8'h18, 16'h8AB0, a0, a1, a2);
        chk("R3 addr ack", int'(a0), 1);
        chk("R3 byte1 ack", int'(a1), 1);
        chk("R3 byte2 ack", int'(a2), 1);
        chk("R4 code", int'(dac_code), 'h0AB);
        chk("R4 pd", int'(pwr_down), 1);
    endtask

    task automatic t_unused_bits();
        logic a0, a1, a2;
        wr_word(8'h18, 16'h400F, a0, a1, a2);
        chk("R4 unused code", int'(dac_code), 0);
        chk("R4 unused pd", int'(pwr_down), 0);
    endtask

    task automatic t_alias_extra();
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(8'h1E, a0);
        send_byte(8'h3F, a1);
        send_byte(8'hF0, a2);
        send_byte(8'h77, a3);
        bus_stop();
        chk("R2 alias ack", int'(a0), 1);
        chk("R3 third byte nack", int'(a3), 0);
        chk("R4 alias code", int'(dac_code), 'h3FF);
        chk("R4 alias pd", int'(pwr_down), 0);
    endtask

    task automatic t_mismatch();
        logic a0, a1, a2;
        wr_word(8'h20, 16'h8120, a0, a1, a2);
        chk("R2 foreign addr nack", int'(a0), 0);
        chk("R2 foreign data nack", int'(a1 | a2), 0);
        chk("R2 foreign code kept", int'(dac_code), 'h3FF);
        chk("R2 foreign pd kept", int'(pwr_down), 0);
    endtask

    task automatic t_read_clear();
        logic a0;
        logic [15:0] w;
        rd_word(1'b1, a0, w);
        chk("R6 read ack", int'(a0), 1);
        chk("R6 read word", int'(w), 'h3FF0);
        chk("R6 code after read", int'(dac_code), 'h3FF);
        rd_word(1'b1, a0, w);
        chk("R7 cleared word", int'(w), 0);
        chk("R7 code kept", int'(dac_code), 'h3FF);
    endtask

    task automatic t_partial();
        logic a0, a1, a2;
        logic [15:0] w;
        wr_word(8'h18, 16'h1230, a0, a1, a2);
        chk("R4 code 123", int'(dac_code), 'h123);
        bus_start();
        send_byte(8'h18, a0);
        send_byte(8'hFF, a1);
        bus_stop();
        chk("R5 partial code kept", int'(dac_code), 'h123);
        chk("R5 partial pd kept", int'(pwr_down), 0);
        rd_word(1'b0, a0, w);
        chk("R7 nack read high byte", int'(w[15:8]), 'h12);
        rd_word(1'b1, a0, w);
        chk("R5 R7 input kept", int'(w), 'h1230);
    endtask

    task automatic t_rep_start();
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(8'h18, a0);
        send_byte(8'h55, a1);
        bus_start();
        send_byte(8'h18, a2);
        send_byte(8'h2A, a3);
        send_byte(8'h50, a1);
        bus_stop();
        chk("R8 second addr ack", int'(a2), 1);
        chk("R8 code", int'(dac_code), 'h2A5);
        chk("R8 pd", int'(pwr_down), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_basic();
        t_unused_bits();
        t_alias_extra();
        t_mismatch();
        t_read_clear();
        t_partial();
        t_rep_start();
        chk("R9 no drive change in high", r9_viol, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule